// File: doc/BRIEF.md
# Paravirtual Device Configuration Register File

This block is the register file behind the configuration memory window of a paravirtual device function. One request/response port carries each access: address, write flag, access size in bytes and write data. Exactly one cycle later the block returns read data and an error flag. The window holds three regions. The common region covers offsets 0x00 to 0x37 and holds the feature paging, device status, queue selection and the per-queue ring setup. A one-byte interrupt status register sits at 0x38. A device-specific window starts at 0x3C and is forwarded to an external port.

Driver software pages through the 64-bit device feature space one 32-bit word at a time. It sets up each virtqueue by selecting it and then writing its size and its three ring addresses. When it takes an interrupt, it reads the status byte, which clears the byte and drops the interrupt line. Every write is checked against the width of its field. Writes that are too wide or too narrow, writes to read-only fields, bad queue selections and accesses outside every region all come back with the error flag set and leave the state as it was.

Top module: `pvdev_cfg_regs`

## Requirements
- R1: After reset, device status (0x14, 1 byte), device feature select (0x00), driver feature select (0x08), driver features (0x0C), queue select (0x16) and every queue's size (0x18) and address words (0x20..0x34) read as 0, and `irq` is low.
- R2: Bits pulsed on `isr_set` are ORed into the status byte at 0x38, and `irq` is high while the byte is nonzero. A read of 0x38 returns the byte and clears it in the same access. Bits set during the clearing read's own cycle survive the clear.
- R3: A read of device features (0x04) returns the `DEV_FEATURES` word when the device feature select (0x00) is 0, the value 1 when the select is 1, and 0 for any other select.
- R4: A write to driver features (0x0C) is stored only while the driver feature select (0x08) is 0. While that select is nonzero, a read of 0x0C returns 0 and a write is accepted but does not change the stored word.
- R5: A write must be 4 bytes wide for 0x00, 0x08, 0x0C and 0x20..0x34, 2 bytes wide for 0x16 and 0x18, and 1 byte wide for 0x14. Any other width returns the error flag and the field keeps its value.
- R6: A 2-byte write to queue select (0x16) with a value at or above `NUM_Q` returns the error flag, and the previous selection is kept.
- R7: Queue enable (0x1C) always reads 0. Config vector (0x10), queue vector (0x1A) and config generation (0x15) also read 0. Writes to 0x10, 0x1A and 0x1C complete without error and have no effect.
- R8: Number of queues (0x12) reads `NUM_Q`. Writes to 0x12, 0x1E, 0x15, 0x04 and 0x38 return the error flag and change nothing.
- R9: Queue notify offset (0x1E) reads the current queue select value.
- R10: Queue size (0x18) and the six address words at 0x20 + 4*k are stored per queue, for the queue selected at the time of the access. Word order is descriptor low/high (k=0,1), available low/high (k=2,3) and used low/high (k=4,5).
- R11: An access at 0x3C <= addr < 0x3C+`DEV_BYTES` raises `dev_req` in its request cycle with `dev_offset` = addr-0x3C and the size, write flag and data copied. `dev_rdata` and `dev_err` from that cycle become the response.
- R12: An access to any other address, including unlisted offsets inside the common region, returns the error flag with read data 0. It raises no `dev_req` and leaves all state unchanged.
- R13: `resp_valid` is high exactly in the cycle after each cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the configuration window |
| req_size | input | 3 | Access width in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-aligned |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_rdata | output | 32 | Read data, 0 on writes and errors |
| resp_err | output | 1 | Access rejected |
| isr_set | input | 8 | Interrupt cause bits to set |
| irq | output | 1 | Interrupt, high while the status byte is nonzero |
| dev_req | output | 1 | Device-specific window access strobe |
| dev_write | output | 1 | Device window write flag |
| dev_offset | output | ADDR_W | Offset within the device window |
| dev_size | output | 3 | Device window access width |
| dev_wdata | output | 32 | Device window write data |
| dev_rdata | input | 32 | Device window read data, same cycle |
| dev_err | input | 1 | Device window error, same cycle |

## Verification
The bench goes after the clear-on-read status byte, both when it is read alone and when a new cause arrives in the same cycle. A design that clears after the set would lose that interrupt, and one that never clears would leave `irq` stuck high. It pages both feature selects through 0, 1 and larger values. A design that decodes the select wrongly either leaks the feature word into upper pages or lets a paged driver-feature write overwrite page 0. It programs all queues with distinct values and reads them back to catch storage that ignores the selection. It also sends out-of-range selects, wrong widths, read-only writes and addresses in the holes of the common region, each of which a loose decoder would accept as a silent state change.

// File: rtl/pvcfg_pkg.sv
package pvcfg_pkg;
  localparam int unsigned NUM_WORDS = 6;
  localparam int unsigned ISR_OFF   = 32'h38;
  localparam int unsigned DEV_BASE  = 32'h3C;

  typedef enum logic [4:0] {
    F_NONE, F_DFSEL, F_DFEAT, F_GFSEL, F_GFEAT, F_VCFG, F_NUMQ, F_STATUS,
    F_CGEN, F_QSEL, F_QSIZE, F_QVEC, F_QEN, F_QNOFF, F_QADDR, F_ISR, F_DEV
  } field_e;
endpackage

// File: rtl/pvcfg_decode.sv
module pvcfg_decode import pvcfg_pkg::*; #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DEV_BYTES = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output field_e            fld,
  output logic [2:0]        word_idx,
  output logic [ADDR_W-1:0] dev_off
);
  logic [31:0] a32;
  assign a32     = 32'(addr);
  assign dev_off = ADDR_W'(a32 - DEV_BASE);

  always_comb begin
    word_idx = 3'd0;
    case (a32)
      32'h00:  fld = F_DFSEL;
      32'h04:  fld = F_DFEAT;
      32'h08:  fld = F_GFSEL;
      32'h0C:  fld = F_GFEAT;
      32'h10:  fld = F_VCFG;
      32'h12:  fld = F_NUMQ;
      32'h14:  fld = F_STATUS;
      32'h15:  fld = F_CGEN;
      32'h16:  fld = F_QSEL;
      32'h18:  fld = F_QSIZE;
      32'h1A:  fld = F_QVEC;
      32'h1C:  fld = F_QEN;
      32'h1E:  fld = F_QNOFF;
      32'h20, 32'h24, 32'h28, 32'h2C, 32'h30, 32'h34: begin
        fld      = F_QADDR;
        word_idx = 3'((a32 - 32'h20) >> 2);
      end
      32'h38:  fld = F_ISR;
      default: fld = (a32 >= DEV_BASE && a32 < DEV_BASE + DEV_BYTES) ? F_DEV : F_NONE;
    endcase
  end
endmodule

// File: rtl/pvcfg_queue_file.sv
module pvcfg_queue_file import pvcfg_pkg::*; #(
  parameter int unsigned NUM_Q  = 4,
  parameter int unsigned QSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QSEL_W-1:0] sel,
  input  logic              size_we,
  input  logic [15:0]       size_wdata,
  input  logic              word_we,
  input  logic [2:0]        word_idx,
  input  logic [31:0]       word_wdata,
  output logic [15:0]       size_rd,
  output logic [31:0]       word_rd
);
  logic [NUM_Q-1:0][15:0]                size_all;
  logic [NUM_Q-1:0][NUM_WORDS-1:0][31:0] words_all;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic                       hit;
    logic [15:0]                sz_r;
    logic [NUM_WORDS-1:0][31:0] wd_r;
    assign hit = (sel == QSEL_W'(q));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             sz_r <= '0;
      else if (size_we && hit) sz_r <= size_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wd_r <= '0;
      else if (word_we && hit) wd_r[word_idx] <= word_wdata;
    end

    assign size_all[q]  = sz_r;
    assign words_all[q] = wd_r;
  end

  assign size_rd = size_all[sel];
  assign word_rd = words_all[sel][word_idx];
endmodule

// File: rtl/pvcfg_isr.sv
module pvcfg_isr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set,
  input  logic       clr,
  output logic [7:0] value,
  output logic       irq
);
  logic [7:0] val_d;
  assign val_d = (clr ? 8'h00 : value) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= 8'h00;
    else        value <= val_d;
  end

  assign irq = |value;
endmodule

// File: rtl/pvdev_cfg_regs.sv
module pvdev_cfg_regs import pvcfg_pkg::*; #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned NUM_Q        = 4,
  parameter int unsigned DEV_BYTES    = 16,
  parameter logic [31:0] DEV_FEATURES = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic              resp_err,
  input  logic [7:0]        isr_set,
  output logic              irq,
  output logic              dev_req,
  output logic              dev_write,
  output logic [ADDR_W-1:0] dev_offset,
  output logic [2:0]        dev_size,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata,
  input  logic              dev_err
);
  localparam int unsigned QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_core_n = rsync[1];

  field_e     fld;
  logic [2:0] widx;
  pvcfg_decode #(.ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES)) u_dec (
    .addr(req_addr), .fld(fld), .word_idx(widx), .dev_off(dev_offset)
  );

  logic wr, rd, sz1, sz2, sz4;
  assign wr  = req_valid &  req_write;
  assign rd  = req_valid & ~req_write;
  assign sz1 = (req_size == 3'd1);
  assign sz2 = (req_size == 3'd2);
  assign sz4 = (req_size == 3'd4);

  logic [31:0]       dfsel_q, dfsel_d, gfsel_q, gfsel_d, gfeat_q, gfeat_d;
  logic [7:0]        status_q, status_d;
  logic [QSEL_W-1:0] qsel_q, qsel_d;
  logic              qsize_we, qword_we, isr_clr, err, rsp_en;
  logic [31:0]       rdata;
  logic [15:0]       qsize_rd;
  logic [31:0]       qword_rd;
  logic [7:0]        isr_val;

  pvcfg_queue_file #(.NUM_Q(NUM_Q), .QSEL_W(QSEL_W)) u_qf (
    .clk(clk), .rst_n(rst_core_n), .sel(qsel_q),
    .size_we(qsize_we), .size_wdata(req_wdata[15:0]),
    .word_we(qword_we), .word_idx(widx), .word_wdata(req_wdata),
    .size_rd(qsize_rd), .word_rd(qword_rd)
  );

  pvcfg_isr u_isr (
    .clk(clk), .rst_n(rst_core_n), .set(isr_set), .clr(isr_clr),
    .value(isr_val), .irq(irq)
  );

  assign dev_req   = req_valid && (fld == F_DEV);
  assign dev_write = req_write;
  assign dev_size  = req_size;
  assign dev_wdata = req_wdata;

  always_comb begin
    dfsel_d = dfsel_q;  gfsel_d = gfsel_q;  gfeat_d = gfeat_q;
    status_d = status_q; qsel_d = qsel_q;
    qsize_we = 1'b0; qword_we = 1'b0; isr_clr = 1'b0;
    err = 1'b0; rdata = 32'h0;
    case (fld)
      F_DFSEL: begin
        rdata = dfsel_q;
        if (wr) begin if (sz4) dfsel_d = req_wdata; else err = 1'b1; end
      end
      F_DFEAT: begin
        rdata = (dfsel_q == 32'd0) ? DEV_FEATURES : (dfsel_q == 32'd1) ? 32'd1 : 32'd0;
        err   = wr;
      end
      F_GFSEL: begin
        rdata = gfsel_q;
        if (wr) begin if (sz4) gfsel_d = req_wdata; else err = 1'b1; end
      end
      F_GFEAT: begin
        rdata = (gfsel_q == 32'd0) ? gfeat_q : 32'd0;
        if (wr) begin
          if (!sz4) err = 1'b1;
          else if (gfsel_q == 32'd0) gfeat_d = req_wdata;
        end
      end
      F_STATUS: begin
        rdata = 32'(status_q);
        if (wr) begin if (sz1) status_d = req_wdata[7:0]; else err = 1'b1; end
      end
      F_QSEL: begin
        rdata = 32'(qsel_q);
        if (wr) begin
          if (!sz2 || req_wdata[15:0] >= 16'(NUM_Q)) err = 1'b1;
          else qsel_d = req_wdata[QSEL_W-1:0];
        end
      end
      F_QSIZE: begin
        rdata = 32'(qsize_rd);
        if (wr) begin if (sz2) qsize_we = 1'b1; else err = 1'b1; end
      end
      F_QADDR: begin
        rdata = qword_rd;
        if (wr) begin if (sz4) qword_we = 1'b1; else err = 1'b1; end
      end
      F_NUMQ:  begin rdata = 32'(NUM_Q); err = wr; end
      F_QNOFF: begin rdata = 32'(qsel_q); err = wr; end
      F_CGEN:  err = wr;
      F_VCFG, F_QVEC, F_QEN: rdata = 32'h0;
      F_ISR: begin
        rdata   = 32'(isr_val);
        isr_clr = rd;
        err     = wr;
      end
      F_DEV: begin
        rdata = dev_rdata;
        err   = dev_err;
      end
      default: err = 1'b1;
    endcase
    if (wr || err) rdata = 32'h0;
  end

  assign rsp_en = req_valid;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      dfsel_q <= '0; gfsel_q <= '0; gfeat_q <= '0; status_q <= '0; qsel_q <= '0;
    end else if (rsp_en) begin
      dfsel_q <= dfsel_d; gfsel_q <= gfsel_d; gfeat_q <= gfeat_d;
      status_q <= status_d; qsel_q <= qsel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      resp_valid <= 1'b0; resp_rdata <= 32'h0; resp_err <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_rdata <= rsp_en ? rdata : 32'h0;
      resp_err   <= rsp_en & err;
    end
  end
endmodule

// File: rtl/pvcfg_checker.sv
module pvcfg_checker #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_Q     = 4,
  parameter int unsigned DEV_BYTES = 16,
  parameter int unsigned QSEL_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_size,
  input logic              resp_valid,
  input logic              resp_err,
  input logic [31:0]       resp_rdata,
  input logic              irq,
  input logic [7:0]        isr_set,
  input logic              dev_req,
  input logic [QSEL_W-1:0] qsel_q
);
  logic [31:0] a32;
  assign a32 = 32'(req_addr);

  a_r13_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && a32 == 32'h38 && isr_set == 8'h00) |=> !irq);
  a_r6_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(qsel_q) < NUM_Q);
  a_r12_unmapped_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && a32 >= 32'h3C + DEV_BYTES) |=> (resp_err && resp_rdata == 32'h0));
  a_r5_status_width: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && a32 == 32'h14 && req_size != 3'd1) |=> resp_err);
  a_r11_dev_only_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> req_valid);
endmodule

bind pvdev_cfg_regs pvcfg_checker #(
  .ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .DEV_BYTES(DEV_BYTES), .QSEL_W(QSEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .resp_valid(resp_valid),
  .resp_err(resp_err), .resp_rdata(resp_rdata), .irq(irq), .isr_set(isr_set),
  .dev_req(dev_req), .qsel_q(qsel_q)
);

// File: tb/sim_pvdev_cfg_regs.sv
`timescale 1ns/1ps
module sim_pvdev_cfg_regs;
  localparam logic [31:0] FEAT = 32'h1234_0081;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = 8'h0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = 32'h0;
  logic        resp_valid, resp_err, irq;
  logic [31:0] resp_rdata;
  logic [7:0]  isr_set = 8'h0;
  logic        dev_req, dev_write, dev_err;
  logic [7:0]  dev_offset;
  logic [2:0]  dev_size;
  logic [31:0] dev_wdata, dev_rdata;

  always #4 clk = ~clk;

  pvdev_cfg_regs #(.ADDR_W(8), .NUM_Q(4), .DEV_BYTES(16), .DEV_FEATURES(FEAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
    .isr_set(isr_set), .irq(irq), .dev_req(dev_req), .dev_write(dev_write),
    .dev_offset(dev_offset), .dev_size(dev_size), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .dev_err(dev_err)
  );

  // device window model
  assign dev_rdata = 32'hA500_0000 | 32'(dev_offset);
  assign dev_err   = dev_req && dev_offset == 8'h0F;

  int unsigned dev_hits = 0;
  logic [7:0]  dev_last_off = 8'h0;
  logic [31:0] dev_last_data = 32'h0;
  always @(posedge clk) if (dev_req) begin
    dev_hits++;
    if (dev_write) begin dev_last_off = dev_offset; dev_last_data = dev_wdata; end
  end

  int unsigned n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] rd;
  logic        er;
  logic        vld;

  task automatic acc(input logic w, input logic [7:0] a, input logic [2:0] s,
                     input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    rd = resp_rdata; er = resp_err; vld = resp_valid;
  endtask

  task automatic t_reset();
    acc(0, 8'h14, 1, 0); check("R1 status", rd, 0);
    check("R13 resp_valid", 32'(vld), 1);
    @(negedge clk); check("R13 idle", 32'(resp_valid), 0);
    acc(0, 8'h00, 4, 0); check("R1 dfsel", rd, 0);
    acc(0, 8'h08, 4, 0); check("R1 gfsel", rd, 0);
    acc(0, 8'h0C, 4, 0); check("R1 gfeat", rd, 0);
    acc(0, 8'h16, 2, 0); check("R1 qsel", rd, 0);
    acc(0, 8'h18, 2, 0); check("R1 qsize", rd, 0);
    acc(0, 8'h34, 4, 0); check("R1 qword", rd, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_isr();
    @(negedge clk); isr_set = 8'h05; @(negedge clk); isr_set = 8'h00;
    check("R2 irq set", 32'(irq), 1);
    acc(0, 8'h38, 1, 0); check("R2 read value", rd, 32'h05);
    check("R2 irq cleared", 32'(irq), 0);
    acc(0, 8'h38, 1, 0); check("R2 read after clear", rd, 0);
    // new cause arriving during the clearing read
    @(negedge clk); isr_set = 8'h01; @(negedge clk); isr_set = 8'h00;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'h38; req_size = 1; isr_set = 8'h02;
    @(negedge clk);
    req_valid = 0; isr_set = 8'h00;
    check("R2 same-cycle read", resp_rdata, 32'h01);
    check("R2 same-cycle irq kept", 32'(irq), 1);
    acc(0, 8'h38, 1, 0); check("R2 same-cycle bit kept", rd, 32'h02);
  endtask

  task automatic t_feat();
    acc(0, 8'h04, 4, 0); check("R3 page0", rd, FEAT);
    acc(1, 8'h00, 4, 1); check("R3 sel write ok", 32'(er), 0);
    acc(0, 8'h04, 4, 0); check("R3 page1", rd, 1);
    acc(1, 8'h00, 4, 7);
    acc(0, 8'h04, 4, 0); check("R3 page7", rd, 0);
    acc(1, 8'h00, 4, 0);
  endtask

  task automatic t_drv();
    acc(1, 8'h0C, 4, 32'hAABB_CCDD); check("R4 store err", 32'(er), 0);
    acc(0, 8'h0C, 4, 0); check("R4 readback", rd, 32'hAABB_CCDD);
    acc(1, 8'h08, 4, 1);
    acc(0, 8'h0C, 4, 0); check("R4 paged read", rd, 0);
    acc(1, 8'h0C, 4, 32'h1111_2222); check("R4 paged write ok", 32'(er), 0);
    acc(1, 8'h08, 4, 0);
    acc(0, 8'h0C, 4, 0); check("R4 page0 kept", rd, 32'hAABB_CCDD);
  endtask

  task automatic t_width();
    acc(1, 8'h14, 1, 32'h0F); check("R5 status ok", 32'(er), 0);
    acc(1, 8'h14, 4, 32'hF0); check("R5 status wide err", 32'(er), 1);
    acc(0, 8'h14, 1, 0); check("R5 status kept", rd, 32'h0F);
    acc(1, 8'h16, 4, 1); check("R5 qsel wide err", 32'(er), 1);
    acc(0, 8'h16, 2, 0); check("R5 qsel kept", rd, 0);
    acc(1, 8'h20, 2, 32'h55); check("R5 qword narrow err", 32'(er), 1);
    acc(0, 8'h20, 4, 0); check("R5 qword kept", rd, 0);
    acc(1, 8'h00, 2, 3); check("R5 dfsel narrow err", 32'(er), 1);
    acc(1, 8'h18, 1, 9); check("R5 qsize narrow err", 32'(er), 1);
  endtask

  task automatic t_qsel();
    acc(1, 8'h16, 2, 2); check("R6 qsel ok", 32'(er), 0);
    acc(0, 8'h1E, 2, 0); check("R9 notify off", rd, 2);
    acc(1, 8'h16, 2, 4); check("R6 qsel range err", 32'(er), 1);
    acc(0, 8'h16, 2, 0); check("R6 qsel kept", rd, 2);
    acc(0, 8'h1E, 2, 0); check("R9 notify off kept", rd, 2);
  endtask

  task automatic t_queues();
    for (int q = 0; q < 4; q++) begin
      acc(1, 8'h16, 2, 32'(q));
      acc(1, 8'h18, 2, 32'(16 * (q + 1)));
      for (int k = 0; k < 6; k++) acc(1, 8'(8'h20 + 4 * k), 4, 32'(q * 256 + k + 32'h1000));
    end
    for (int q = 3; q >= 0; q--) begin
      acc(1, 8'h16, 2, 32'(q));
      acc(0, 8'h18, 2, 0); check("R10 qsize", rd, 32'(16 * (q + 1)));
      for (int k = 0; k < 6; k++) begin
        acc(0, 8'(8'h20 + 4 * k), 4, 0);
        check("R10 qword", rd, 32'(q * 256 + k + 32'h1000));
      end
    end
  endtask

  task automatic t_ignored();
    acc(1, 8'h1C, 2, 1); check("R7 qen write ok", 32'(er), 0);
    acc(0, 8'h1C, 2, 0); check("R7 qen reads 0", rd, 0);
    acc(1, 8'h10, 2, 5); check("R7 vcfg write ok", 32'(er), 0);
    acc(0, 8'h10, 2, 0); check("R7 vcfg reads 0", rd, 0);
    acc(1, 8'h1A, 2, 5); check("R7 qvec write ok", 32'(er), 0);
    acc(0, 8'h1A, 2, 0); check("R7 qvec reads 0", rd, 0);
    acc(0, 8'h15, 1, 0); check("R7 cgen reads 0", rd, 0);
    acc(0, 8'h16, 2, 0); check("R7 qsel untouched", rd, 0);
  endtask

  task automatic t_ro();
    acc(0, 8'h12, 2, 0); check("R8 numq", rd, 4);
    acc(1, 8'h12, 2, 9); check("R8 numq wr err", 32'(er), 1);
    acc(1, 8'h1E, 2, 3); check("R8 noff wr err", 32'(er), 1);
    acc(1, 8'h15, 1, 3); check("R8 cgen wr err", 32'(er), 1);
    acc(1, 8'h04, 4, 3); check("R8 dfeat wr err", 32'(er), 1);
    acc(1, 8'h38, 1, 3); check("R8 isr wr err", 32'(er), 1);
    check("R8 isr wr no irq", 32'(irq), 0);
    acc(0, 8'h12, 2, 0); check("R8 numq kept", rd, 4);
    acc(0, 8'h1E, 2, 0); check("R8 noff kept", rd, 0);
  endtask

  task automatic t_dev();
    int unsigned h0;
    h0 = dev_hits;
    acc(0, 8'h40, 4, 0); check("R11 dev read", rd, 32'hA500_0004);
    check("R11 dev read ok", 32'(er), 0);
    acc(1, 8'h44, 2, 32'hBEEF); check("R11 dev write offset", 32'(dev_last_off), 8);
    check("R11 dev write data", dev_last_data, 32'hBEEF);
    acc(0, 8'h4B, 1, 0); check("R11 dev err", 32'(er), 1);
    check("R11 dev hits", dev_hits - h0, 3);
  endtask

  task automatic t_unmapped();
    int unsigned h0;
    h0 = dev_hits;
    acc(0, 8'h01, 4, 0); check("R12 hole err", 32'(er), 1);
    check("R12 hole data", rd, 0);
    acc(0, 8'h4C, 4, 0); check("R12 past window err", 32'(er), 1);
    acc(1, 8'h17, 1, 3); check("R12 qsel hole wr err", 32'(er), 1);
    acc(0, 8'h16, 2, 0); check("R12 qsel unchanged", rd, 0);
    acc(1, 8'hF0, 4, 7); check("R12 high wr err", 32'(er), 1);
    check("R12 no dev_req", dev_hits - h0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset(); t_isr(); t_feat(); t_drv(); t_width(); t_qsel();
    t_queues(); t_ignored(); t_ro(); t_dev(); t_unmapped();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule